// File: doc/BRIEF.md
# Divided Down-Count Interval Timer

This block is a 32-bit down-counting interval timer for a processor's local interrupt logic. A per-cycle enable input marks the core cycles that count. A power-of-two prescaler turns those cycles into timer ticks, and each tick takes one from the running count. When the count expires, the block raises a one-cycle interrupt strobe with a programmed 8-bit vector. The strobe is always a fixed-mode interrupt. The logic that receives the strobe is outside this block.

Software reaches four registers through a simple port. The port has a write strobe, a 2-bit register select and a combinational read-data bus. The registers are the vector entry, the start count, the running count and the divider setting. The vector entry carries the vector, a mask bit and a mode bit. The mode bit selects between one-shot operation, which stops at zero, and periodic operation, which reloads from the start count.

Top module: `ltmr_top`

## Requirements
- R1: After reset, the vector entry reads 0x00010000 (masked, vector 0), and the divider, start count and running count registers all read 0. The strobe output is low.
- R2: A write to the start count (select 1) loads both the start count and the running count with the written value. The running count reads back at select 2.
- R3: A write to the running count (select 2) replaces the running count and leaves the start count unchanged. Counting continues from the new value.
- R4: The timer is idle while the start count is zero, or while one-shot mode is selected and the running count is zero. While idle, the running count does not change and no strobe is raised.
- R5: The divider setting (select 3) uses only bits 3, 1 and 0. The code {b3,b1,b0} selects the divisor: 000=2, 001=4, 010=8, 011=16, 100=32, 101=64, 110=128, 111=1. All other bits read back as 0.
- R6: The running count drops by one for every D counted cycles, where D is the divisor. Cycles with the enable input low do not count. A write to the start count, the running count or the divider restarts the prescaler. After a start-count write of N with the enable held high, the strobe is seen N×D clock edges after the write edge.
- R7: When the count expires, irq_fire is high for one cycle and irq_vector holds bits 7:0 of the vector entry. If the mask bit (bit 16) is set, no strobe is raised, but the count still runs to expiry.
- R8: With the mode bit (bit 17) set to 1 (periodic), the expiring tick reloads the running count from the start count, so the strobe repeats every N×D cycles. With the mode bit at 0 (one-shot), the count stops at zero.
- R9: The vector entry (select 0) stores bits 7:0, 16 and 17 only. All other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Marks a core cycle that counts toward the prescaler |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 vector entry, 1 start count, 2 running count, 3 divider |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq_fire | output | 1 | One-cycle interrupt strobe on expiry |
| irq_vector | output | 8 | Vector that goes with the strobe |

## Verification
Some rules can be checked on every cycle, and the assertions cover these:
- the running count holds while the timer is idle;
- a load replaces the running count;
- an ordinary tick takes exactly one from the count, and a periodic expiry reloads the start count;
- a strobe never follows a masked entry and always carries the vector that was stored at the time.

Other behaviour shows up only in the bench's scenarios:
- the end-to-end expiry latency for several divider codes;
- the repeat period in periodic mode;
- the halt of counting while the enable input is low;
- the register readback masks.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

    localparam int DATA_W    = 32;
    localparam int VEC_W     = 8;
    localparam int SEL_W     = 2;
    localparam int MAX_SHIFT = 7;
    localparam int PRE_W     = MAX_SHIFT;

    typedef enum logic [SEL_W-1:0] {
        SEL_ENTRY = 2'd0,
        SEL_START = 2'd1,
        SEL_RUN   = 2'd2,
        SEL_DIV   = 2'd3
    } sel_e;

    typedef struct packed {
        logic              periodic;
        logic              masked;
        logic [VEC_W-1:0]  vector;
    } entry_t;

    // {b3,b1,b0}: 111 selects divide-by-1, otherwise the divisor is 2^(code+1)
    function automatic logic [2:0] div_shift(input logic [2:0] code);
        return (code == 3'b111) ? 3'd0 : code + 3'd1;
    endfunction

    function automatic logic [DATA_W-1:0] entry_word(input entry_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VEC_W-1:0] = e.vector;
        w[16] = e.masked;
        w[17] = e.periodic;
        return w;
    endfunction

endpackage

// File: rtl/ltmr_prescale.sv
module ltmr_prescale
    import ltmr_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       cyc_en,
    input  logic [2:0] shift,
    output logic       tick
);

    logic [PW-1:0] pre_cnt;
    logic [PW-1:0] limit;

    always_comb begin
        limit = PW'((1 << shift) - 1);
        tick  = cyc_en && !clear && (pre_cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_cnt <= '0;
        end else if (cyc_en) begin
            pre_cnt <= tick ? '0 : pre_cnt + PW'(1);
        end
    end

    // R6
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!cyc_en && !clear) |=> $stable(pre_cnt));

endmodule

// File: rtl/ltmr_count.sv
module ltmr_count #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic [CW-1:0] start,
    input  logic          periodic,
    output logic [CW-1:0] cur,
    output logic          expire,
    output logic          idle
);

    logic hit;
    logic last;

    always_comb begin
        idle   = (start == '0) || (!periodic && cur == '0);
        hit    = tick && !idle && !ld;
        last   = (cur < CW'(2));
        expire = hit && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (ld) begin
            cur <= ld_val;
        end else if (hit) begin
            if (last) cur <= periodic ? start : '0;
            else      cur <= cur - CW'(1);
        end
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> cur == $past(ld_val));

    // R4
    oneshot_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!periodic && cur == '0 && !ld) |=> cur == '0);

    // R4
    zero_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start == '0 && !ld) |=> $stable(cur));

    // R6
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && start != '0 && cur > CW'(1)) |=> cur == $past(cur) - CW'(1));

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && periodic && start != '0 && cur < CW'(2)) |=> cur == $past(start));

endmodule

// File: rtl/ltmr_top.sv
module ltmr_top
    import ltmr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_en,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_fire,
    output logic [VW-1:0] irq_vector
);

    entry_t        entry_q;
    logic [2:0]    div_q;
    logic [DW-1:0] start_q;
    logic [DW-1:0] cur;
    logic          wr_entry, wr_start, wr_run, wr_div;
    logic          tick, expire, idle, pre_clr;

    always_comb begin
        wr_entry = reg_we && (sel_e'(reg_sel) == SEL_ENTRY);
        wr_start = reg_we && (sel_e'(reg_sel) == SEL_START);
        wr_run   = reg_we && (sel_e'(reg_sel) == SEL_RUN);
        wr_div   = reg_we && (sel_e'(reg_sel) == SEL_DIV);
        pre_clr  = wr_start || wr_run || wr_div || idle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q    <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
            div_q      <= '0;
            start_q    <= '0;
            irq_fire   <= 1'b0;
            irq_vector <= '0;
        end else begin
            if (wr_entry) entry_q <= '{periodic: reg_wdata[17], masked: reg_wdata[16],
                                       vector: reg_wdata[VW-1:0]};
            if (wr_div)   div_q   <= {reg_wdata[3], reg_wdata[1:0]};
            if (wr_start) start_q <= reg_wdata;
            irq_fire <= expire && !entry_q.masked;
            if (expire && !entry_q.masked) irq_vector <= entry_q.vector;
        end
    end

    always_comb begin
        unique case (sel_e'(reg_sel))
            SEL_ENTRY: reg_rdata = entry_word(entry_q);
            SEL_START: reg_rdata = start_q;
            SEL_RUN:   reg_rdata = cur;
            default:   reg_rdata = {{(DW-4){1'b0}}, div_q[2], 1'b0, div_q[1:0]};
        endcase
    end

    ltmr_prescale #(.PW(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clear  (pre_clr),
        .cyc_en (cyc_en),
        .shift  (div_shift(div_q)),
        .tick   (tick)
    );

    ltmr_count #(.CW(DW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ld       (wr_start || wr_run),
        .ld_val   (reg_wdata),
        .start    (start_q),
        .periodic (entry_q.periodic),
        .cur      (cur),
        .expire   (expire),
        .idle     (idle)
    );

    // R7
    fire_vector_chk: assert property (@(posedge clk) disable iff (rst)
        irq_fire |-> irq_vector == $past(entry_q.vector));

    // R7
    fire_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        irq_fire |-> !$past(entry_q.masked));

endmodule

// File: tb/tb_ltmr_top.sv
module tb_ltmr_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_en;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_fire;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    ltmr_top dut (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_fire(irq_fire), .irq_vector(irq_vector)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    task automatic wait_fire(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (irq_fire) return;
        end
        n = -1;
    endtask

    task automatic count_fires(input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (irq_fire) n++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); chk("R1 entry", v, 32'h0001_0000);
        rd(2'd3, v); chk("R1 div", v, 32'h0);
        rd(2'd1, v); chk("R1 start", v, 32'h0);
        rd(2'd2, v); chk("R1 run", v, 32'h0);
        chk("R1 fire", {31'b0, irq_fire}, 32'h0);
    endtask

    task automatic t_fields;
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R9 entry mask", v, 32'h0003_00FF);
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R5 div mask", v, 32'h0000_000B);
    endtask

    task automatic t_oneshot;
        logic [31:0] v; int n;
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h0000_0040);
        wr(2'd1, 32'd5);
        rd(2'd1, v); chk("R2 start", v, 32'd5);
        rd(2'd2, v); chk("R2 run", v, 32'd5);
        wait_fire(100, n); chk("R6 latency div1", n, 32'd5);
        chk("R7 vector", {24'b0, irq_vector}, 32'h40);
        @(posedge clk); @(negedge clk);
        chk("R7 one cycle", {31'b0, irq_fire}, 32'h0);
        count_fires(20, n); chk("R8 oneshot stops", n, 32'd0);
        rd(2'd2, v); chk("R4 run at zero", v, 32'd0);
    endtask

    task automatic t_dividers;
        int n;
        wr(2'd3, 32'h0); wr(2'd1, 32'd3);
        wait_fire(1000, n); chk("R5 div2", n, 32'd6);
        wr(2'd3, 32'h3); wr(2'd1, 32'd4);
        wait_fire(1000, n); chk("R5 div16", n, 32'd64);
        wr(2'd3, 32'hA); wr(2'd1, 32'd2);
        wait_fire(1000, n); chk("R5 div128", n, 32'd256);
    endtask

    task automatic t_periodic;
        int n;
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h0002_0055);
        wr(2'd1, 32'd4);
        wait_fire(100, n); chk("R8 first period", n, 32'd4);
        wait_fire(100, n); chk("R8 second period", n, 32'd4);
        chk("R7 periodic vector", {24'b0, irq_vector}, 32'h55);
        wr(2'd1, 32'd0);
        count_fires(20, n); chk("R4 start zero stops", n, 32'd0);
    endtask

    task automatic t_masked;
        logic [31:0] v; int n;
        wr(2'd0, 32'h0001_0033);
        wr(2'd1, 32'd3);
        count_fires(10, n); chk("R7 masked no fire", n, 32'd0);
        rd(2'd2, v); chk("R7 masked still counts", v, 32'd0);
    endtask

    task automatic t_idle_zero_start;
        logic [31:0] v; int n;
        wr(2'd0, 32'h0000_0021);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd7);
        count_fires(20, n); chk("R4 idle no fire", n, 32'd0);
        rd(2'd2, v); chk("R4 idle holds", v, 32'd7);
    endtask

    task automatic t_run_write;
        logic [31:0] v; int n;
        wr(2'd1, 32'd100);
        wr(2'd2, 32'd3);
        rd(2'd1, v); chk("R3 start unchanged", v, 32'd100);
        wait_fire(200, n); chk("R3 run replaced", n, 32'd3);
    endtask

    task automatic t_enable_gate;
        logic [31:0] v; int n;
        cyc_en = 1'b0;
        wr(2'd1, 32'd5);
        count_fires(10, n); chk("R6 gated no fire", n, 32'd0);
        rd(2'd2, v); chk("R6 gated hold", v, 32'd5);
        cyc_en = 1'b1;
        wait_fire(100, n); chk("R6 resumed latency", n, 32'd5);
    endtask

    initial begin
        rst = 1'b1; cyc_en = 1'b1; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fields();
        t_oneshot();
        t_dividers();
        t_periodic();
        t_masked();
        t_idle_zero_start();
        t_run_write();
        t_enable_gate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule